// File: doc/BRIEF.md
# Shared-Bus Multicycle Datapath

This block is the 32-bit datapath of a multicycle processor whose instructions move data from memory to memory. It holds a program counter, an opcode register, three argument registers, two operand registers that feed the arithmetic units, a memory address register and a small word-addressed memory. All of them talk over a single shared bus. An external sequencing controller sets, in every cycle, one bus source through a one-hot drive vector and any set of destinations through a write vector. The block sends back only the opcode and two comparison flags, which the controller needs to pick its next state.

The functional units are an incrementer on the program counter and units for add, subtract, multiply, divide, AND, OR, NOT, shift left and shift right. Each one places its result on the bus only when its drive bit is set. Multiply and divide are slow units with no handshake. The controller reads them after fixed wait windows that are counted from the cycle in which it writes the address register, which follows the load of the second operand. A clock-valid input stalls every register and memory update. A synchronous reset clears the registers.

Top module: `dp_core`

## Requirements
- R1: All registers are 32 bits wide. A register loads the bus value on a rising clock edge when its write bit is set. The write bits are: 0 program counter, 1 opcode, 2 arg1, 3 arg2, 4 arg3, 5 operand A, 6 operand B, 7 memory address.
- R2: The drive bits are: 0 program counter, 1 incremented program counter, 2 arg1, 3 arg2, 4 arg3, 5 memory read data, 6 sum, 7 difference, 8 product, 9 quotient, 10 AND, 11 OR, 12 NOT, 13 left shift, 14 right shift. The bus carries the source whose bit is set and reads zero when no drive bit is set. Setting more than one drive bit in a cycle is illegal and is flagged.
- R3: The incrementer source equals the program counter plus one, modulo 2^32.
- R4: Sum, difference, AND and OR combine operand A with operand B in that order (difference is A minus B, modulo 2^32). NOT inverts operand A alone.
- R5: Left shift is A << B and right shift is a logical A >> B. A shift amount B of 32 or more gives zero.
- R6: The equality flag reports A == B and the less-than flag reports A < B as an unsigned compare. Both follow the operand registers with no added cycle.
- R7: A memory read places the word at the address register (modulo the memory depth) on the bus in the same cycle. A memory write stores the bus value at that address on the clock edge.
- R8: With steady operands, the product (low 32 bits of A*B) is valid in the second cycle after the cycle in which the address register is written following the operand B load.
- R9: With steady operands, the unsigned quotient A/B is valid no later than 13 cycles after that address-write cycle. Division by zero gives all ones.
- R10: Driving the program counter during a memory write stores the current program counter value in memory.
- R11: A synchronous reset clears every register to zero. After reset the opcode reads 0, the equality flag reads 1 and the less-than flag reads 0.
- R12: While clock-valid is low, no register and no memory word changes, whatever the write bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock-valid; low stalls all updates |
| wr_en | input | 8 | Register write bits (positions in R1) |
| drv_en | input | 15 | One-hot bus drive bits (positions in R2) |
| mem_wr | input | 1 | Store bus value at the address register |
| opcode | output | 32 | Opcode register value |
| eq_flag | output | 1 | Operand A equals operand B |
| lt_flag | output | 1 | Operand A below operand B, unsigned |

## Verification
The bench goes after operand order: subtracting a larger value from a smaller one catches swapped inputs, which would give the two's complement negation rather than A minus B. It compares 0x80000000 against 1 to expose a signed compare, which would invert the less-than flag. It uses a shift amount of 32 to catch a shifter that keeps only the low five bits and would return the input unchanged, and a divisor of zero to catch a divider that gives zero. It reads the product and the quotient in the exact last cycle each window allows, so a slower unit reads a stale value. It also tries writes with clock-valid low to catch an update that is not gated.

// File: rtl/dp_pkg.sv
package dp_pkg;
    // register write-enable bit positions
    localparam int WR_PC   = 0;
    localparam int WR_OPC  = 1;
    localparam int WR_A1   = 2;
    localparam int WR_A2   = 3;
    localparam int WR_A3   = 4;
    localparam int WR_OP1  = 5;
    localparam int WR_OP2  = 6;
    localparam int WR_MAR  = 7;
    localparam int WR_N    = 8;
    // bus drive-enable bit positions
    localparam int DRV_PC  = 0;
    localparam int DRV_INC = 1;
    localparam int DRV_A1  = 2;
    localparam int DRV_A2  = 3;
    localparam int DRV_A3  = 4;
    localparam int DRV_MEM = 5;
    localparam int DRV_ADD = 6;
    localparam int DRV_SUB = 7;
    localparam int DRV_MUL = 8;
    localparam int DRV_DIV = 9;
    localparam int DRV_AND = 10;
    localparam int DRV_OR  = 11;
    localparam int DRV_NOT = 12;
    localparam int DRV_SHL = 13;
    localparam int DRV_SHR = 14;
    localparam int DRV_N   = 15;
endpackage

// File: rtl/dp_alu.sv
module dp_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic [W-1:0] dif,
    output logic [W-1:0] band,
    output logic [W-1:0] bor,
    output logic [W-1:0] bnot,
    output logic [W-1:0] shl,
    output logic [W-1:0] shr,
    output logic         eq,
    output logic         lt
);
    localparam int SW = $clog2(W);
    localparam logic [W-1:0] W_LIM = W[W-1:0];

    logic big_shift;

    always_comb begin
        big_shift = (op_b >= W_LIM);
        sum  = op_a + op_b;
        dif  = op_a - op_b;
        band = op_a & op_b;
        bor  = op_a | op_b;
        bnot = ~op_a;
        shl  = big_shift ? '0 : (op_a << op_b[SW-1:0]);
        shr  = big_shift ? '0 : (op_a >> op_b[SW-1:0]);
        eq   = (op_a == op_b);
        lt   = (op_a < op_b);
    end
endmodule

// File: rtl/dp_mul.sv
module dp_mul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] prod
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } mul_t;

    mul_t mul_d, mul_q;
    logic [W-1:0] prod_now;

    always_comb begin
        prod_now = op_a * op_b;
        mul_d    = mul_q;
        if (ce) begin
            mul_d.s1 = prod_now;
            mul_d.s2 = mul_q.s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mul_q <= '0;
        else     mul_q <= mul_d;
    end

    assign prod = mul_q.s2;

    AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (ce && $past(ce)) |=> (prod == $past(prod_now, 2))); // R8
endmodule

// File: rtl/dp_div.sv
module dp_div #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quo
);
    localparam int STEPS = W / STEP;
    localparam int CW    = $clog2(STEPS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvd_cap;
        logic [W-1:0]  dvs_cap;
    } div_t;

    div_t div_d, div_q;
    logic [W:0]   r_t;
    logic [W-1:0] q_t;
    logic         restart;
    logic         done;

    always_comb begin
        div_d   = div_q;
        r_t     = div_q.rem;
        q_t     = div_q.quo;
        restart = (dvd != div_q.dvd_cap) || (dvs != div_q.dvs_cap);
        if (ce) begin
            if (restart) begin
                div_d.dvd_cap = dvd;
                div_d.dvs_cap = dvs;
                div_d.rem     = '0;
                div_d.quo     = dvd;
                div_d.cnt     = CW'(STEPS);
            end else if (div_q.cnt != '0) begin
                for (int i = 0; i < STEP; i++) begin
                    r_t = {r_t[W-1:0], q_t[W-1]};
                    q_t = {q_t[W-2:0], 1'b0};
                    if (r_t >= {1'b0, div_q.dvs_cap}) begin
                        r_t    = r_t - {1'b0, div_q.dvs_cap};
                        q_t[0] = 1'b1;
                    end
                end
                div_d.rem = r_t;
                div_d.quo = q_t;
                div_d.cnt = div_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            div_q.quo <= '1;
        end else begin
            div_q <= div_d;
        end
    end

    assign quo  = div_q.quo;
    assign done = (div_q.cnt == '0);

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (rst)
        (done && div_q.dvs_cap != '0) |->
        (({{W{1'b0}}, div_q.quo} * {{W{1'b0}}, div_q.dvs_cap}) + (2*W)'(div_q.rem)
            == {{W{1'b0}}, div_q.dvd_cap})); // R9
    AST_DIV_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && div_q.dvs_cap == '0) |-> (div_q.quo == '1)); // R9
endmodule

// File: rtl/dp_mem.sv
module dp_mem #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         we,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  words [DEPTH];
    logic [AW-1:0] idx;
    logic          unused_addr_hi;

    assign idx            = addr[AW-1:0];
    assign unused_addr_hi = ^addr[W-1:AW];
    assign rdata          = words[idx];

    always_ff @(posedge clk) begin
        if (we) words[idx] <= wdata;
    end
endmodule

// File: rtl/dp_core.sv
module dp_core
    import dp_pkg::*;
#(
    parameter int W        = 32,
    parameter int DEPTH    = 64,
    parameter int DIV_STEP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic [WR_N-1:0]  wr_en,
    input  logic [DRV_N-1:0] drv_en,
    input  logic             mem_wr,
    output logic [W-1:0]     opcode,
    output logic             eq_flag,
    output logic             lt_flag
);
    typedef struct packed {
        logic [W-1:0] pc;
        logic [W-1:0] opc;
        logic [W-1:0] a1;
        logic [W-1:0] a2;
        logic [W-1:0] a3;
        logic [W-1:0] op1;
        logic [W-1:0] op2;
        logic [W-1:0] mar;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [W-1:0] bus;
    logic [W-1:0] src [DRV_N];
    logic [W-1:0] sum, dif, band, bor, bnot, shl, shr, prod, quo, rdata;

    dp_alu #(.W(W)) u_alu (
        .op_a(regs_q.op1), .op_b(regs_q.op2),
        .sum(sum), .dif(dif), .band(band), .bor(bor), .bnot(bnot),
        .shl(shl), .shr(shr), .eq(eq_flag), .lt(lt_flag)
    );

    dp_mul #(.W(W)) u_mul (
        .clk(clk), .rst(rst), .ce(clk_en),
        .op_a(regs_q.op1), .op_b(regs_q.op2), .prod(prod)
    );

    dp_div #(.W(W), .STEP(DIV_STEP)) u_div (
        .clk(clk), .rst(rst), .ce(clk_en),
        .dvd(regs_q.op1), .dvs(regs_q.op2), .quo(quo)
    );

    dp_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(clk_en && mem_wr), .addr(regs_q.mar),
        .wdata(bus), .rdata(rdata)
    );

    // source table for the shared bus
    always_comb begin
        src[DRV_PC]  = regs_q.pc;
        src[DRV_INC] = regs_q.pc + W'(1);
        src[DRV_A1]  = regs_q.a1;
        src[DRV_A2]  = regs_q.a2;
        src[DRV_A3]  = regs_q.a3;
        src[DRV_MEM] = rdata;
        src[DRV_ADD] = sum;
        src[DRV_SUB] = dif;
        src[DRV_MUL] = prod;
        src[DRV_DIV] = quo;
        src[DRV_AND] = band;
        src[DRV_OR]  = bor;
        src[DRV_NOT] = bnot;
        src[DRV_SHL] = shl;
        src[DRV_SHR] = shr;
    end

    // masked OR of all sources; idle bus reads zero
    always_comb begin
        bus = '0;
        for (int i = 0; i < DRV_N; i++) begin
            if (drv_en[i]) bus = bus | src[i];
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (clk_en) begin
            if (wr_en[WR_PC])  regs_d.pc  = bus;
            if (wr_en[WR_OPC]) regs_d.opc = bus;
            if (wr_en[WR_A1])  regs_d.a1  = bus;
            if (wr_en[WR_A2])  regs_d.a2  = bus;
            if (wr_en[WR_A3])  regs_d.a3  = bus;
            if (wr_en[WR_OP1]) regs_d.op1 = bus;
            if (wr_en[WR_OP2]) regs_d.op2 = bus;
            if (wr_en[WR_MAR]) regs_d.mar = bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign opcode = regs_q.opc;

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $countones(drv_en) <= 1); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(regs_q)); // R12
    AST_OPCODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (clk_en && wr_en[WR_OPC]) |=> (opcode == $past(bus))); // R1
endmodule

// File: tb/tb_dp_core.sv
module tb_dp_core;
    import dp_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clk_en = 1'b1;
    logic [WR_N-1:0]  wr_en = '0;
    logic [DRV_N-1:0] drv_en = '0;
    logic             mem_wr = 1'b0;
    logic [31:0]      opcode;
    logic             eq_flag, lt_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    dp_core dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .wr_en(wr_en),
        .drv_en(drv_en), .mem_wr(mem_wr), .opcode(opcode),
        .eq_flag(eq_flag), .lt_flag(lt_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WR_N-1:0] wb(int i);
        return WR_N'(1) << i;
    endfunction

    function automatic logic [DRV_N-1:0] db(int i);
        return DRV_N'(1) << i;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: inputs set at a falling edge, held across the rising edge
    task automatic step(logic [WR_N-1:0] w, logic [DRV_N-1:0] d, logic m);
        wr_en = w; drv_en = d; mem_wr = m;
        @(negedge clk);
        wr_en = '0; drv_en = '0; mem_wr = 1'b0;
    endtask

    // builds val in operand A, leaves operand B at zero (clobbers PC)
    task automatic build_op1(logic [31:0] val);
        step(wb(WR_PC), '0, 1'b0);
        step(wb(WR_OP2), db(DRV_INC), 1'b0);
        step(wb(WR_OP1), '0, 1'b0);
        for (int i = 31; i >= 0; i--) begin
            step(wb(WR_OP1), db(DRV_SHL), 1'b0);
            if (val[i]) step(wb(WR_OP1), db(DRV_OR), 1'b0);
        end
        step(wb(WR_OP2), '0, 1'b0);
    endtask

    task automatic put(logic [31:0] val, logic [WR_N-1:0] w, logic m);
        build_op1(val);
        step(w, db(DRV_ADD), m);
    endtask

    task automatic rd(int src, output logic [31:0] v);
        step(wb(WR_OPC), db(src), 1'b0);
        v = opcode;
    endtask

    task automatic set_ops(logic [31:0] a, logic [31:0] b);
        put(a, wb(WR_A1), 1'b0);
        put(b, wb(WR_A3), 1'b0);
        step(wb(WR_OP1), db(DRV_A1), 1'b0);
        step(wb(WR_OP2), db(DRV_A3), 1'b0);
    endtask

    task automatic t_reset();
        check("R11 opcode after reset", opcode, 32'h0);
        check("R11 eq after reset", {31'b0, eq_flag}, 32'h1);
        check("R11 lt after reset", {31'b0, lt_flag}, 32'h0);
    endtask

    task automatic t_load_idle();
        logic [31:0] v;
        put(32'h1234_5678, wb(WR_A2), 1'b0);
        rd(DRV_A2, v);
        check("R1 register load", v, 32'h1234_5678);
        step(wb(WR_OPC), '0, 1'b0);
        check("R2 idle bus reads zero", opcode, 32'h0);
    endtask

    task automatic t_inc();
        logic [31:0] v;
        step(wb(WR_PC), '0, 1'b0);
        for (int i = 0; i < 3; i++) step(wb(WR_PC), db(DRV_INC), 1'b0);
        rd(DRV_PC, v);
        check("R3 pc after three increments", v, 32'd3);
        rd(DRV_INC, v);
        check("R3 incrementer", v, 32'd4);
        put(32'hFFFF_FFFF, wb(WR_PC), 1'b0);
        rd(DRV_INC, v);
        check("R3 incrementer wrap", v, 32'h0);
    endtask

    task automatic t_alu();
        logic [31:0] v;
        logic [31:0] a = 32'hF0F0_1234;
        logic [31:0] b = 32'h0000_0005;
        set_ops(a, b);
        rd(DRV_ADD, v); check("R4 add", v, a + b);
        rd(DRV_SUB, v); check("R4 sub", v, a - b);
        rd(DRV_AND, v); check("R4 and", v, a & b);
        rd(DRV_OR,  v); check("R4 or",  v, a | b);
        rd(DRV_NOT, v); check("R4 not", v, ~a);
        rd(DRV_SHL, v); check("R5 shift left", v, a << 5);
        rd(DRV_SHR, v); check("R5 shift right", v, a >> 5);
        set_ops(32'd3, 32'd5);
        rd(DRV_SUB, v); check("R4 sub order", v, 32'hFFFF_FFFE);
    endtask

    task automatic t_shift_big();
        logic [31:0] v;
        set_ops(32'hDEAD_BEEF, 32'd32);
        rd(DRV_SHL, v); check("R5 shift left by 32", v, 32'h0);
        rd(DRV_SHR, v); check("R5 shift right by 32", v, 32'h0);
        set_ops(32'hDEAD_BEEF, 32'd31);
        rd(DRV_SHR, v); check("R5 shift right by 31", v, 32'h1);
    endtask

    task automatic t_cmp();
        set_ops(32'h8000_0000, 32'd1);
        check("R6 eq big vs 1", {31'b0, eq_flag}, 32'h0);
        check("R6 lt unsigned big vs 1", {31'b0, lt_flag}, 32'h0);
        set_ops(32'd1, 32'h8000_0000);
        check("R6 lt unsigned 1 vs big", {31'b0, lt_flag}, 32'h1);
        set_ops(32'd7, 32'd7);
        check("R6 eq equal", {31'b0, eq_flag}, 32'h1);
        check("R6 lt equal", {31'b0, lt_flag}, 32'h0);
    endtask

    task automatic t_mem();
        logic [31:0] v;
        put(32'd5, wb(WR_MAR), 1'b0);
        put(32'hCAFE_0005, '0, 1'b1);
        put(32'd6, wb(WR_MAR), 1'b0);
        put(32'hBEEF_0006, '0, 1'b1);
        put(32'd5, wb(WR_MAR), 1'b0);
        rd(DRV_MEM, v); check("R7 memory word 5", v, 32'hCAFE_0005);
        put(32'd6, wb(WR_MAR), 1'b0);
        rd(DRV_MEM, v); check("R7 memory word 6", v, 32'hBEEF_0006);
    endtask

    task automatic t_mul();
        logic [31:0] v;
        logic [63:0] full;
        logic [31:0] a = 32'h0012_3457;
        logic [31:0] b = 32'h0001_0203;
        full = {32'b0, a} * {32'b0, b};
        set_ops(a, b);
        step(wb(WR_MAR), db(DRV_A1), 1'b0);
        step('0, '0, 1'b0);
        rd(DRV_MUL, v);
        check("R8 product at second cycle", v, full[31:0]);
    endtask

    task automatic div_case(string req, logic [31:0] a, logic [31:0] b, logic [31:0] exp);
        logic [31:0] v;
        set_ops(a, b);
        step(wb(WR_MAR), db(DRV_A1), 1'b0);
        repeat (12) step('0, '0, 1'b0);
        rd(DRV_DIV, v);
        check(req, v, exp);
    endtask

    task automatic t_div();
        div_case("R9 quotient 1000/7", 32'd1000, 32'd7, 32'd142);
        div_case("R9 quotient max/3", 32'hFFFF_FFFF, 32'd3, 32'h5555_5555);
        div_case("R9 divide by zero", 32'd1234, 32'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_call();
        logic [31:0] v;
        put(32'd9, wb(WR_MAR), 1'b0);
        put(32'h0000_0057, wb(WR_PC), 1'b0);
        step('0, db(DRV_PC), 1'b1);
        put(32'd9, wb(WR_MAR), 1'b0);
        rd(DRV_MEM, v);
        check("R10 pc stored by call", v, 32'h0000_0057);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        put(32'h0000_ABCD, wb(WR_OPC), 1'b0);
        clk_en = 1'b0;
        step(wb(WR_OPC), '0, 1'b0);
        clk_en = 1'b1;
        check("R12 opcode held while stalled", opcode, 32'h0000_ABCD);
        put(32'd3, wb(WR_MAR), 1'b0);
        put(32'h0000_0011, '0, 1'b1);
        build_op1(32'h0000_0022);
        clk_en = 1'b0;
        step('0, db(DRV_ADD), 1'b1);
        clk_en = 1'b1;
        rd(DRV_MEM, v);
        check("R12 memory held while stalled", v, 32'h0000_0011);
    endtask

    task automatic t_sync_reset();
        put(32'h0000_0099, wb(WR_OPC), 1'b0);
        set_ops(32'd4, 32'd9);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 opcode cleared", opcode, 32'h0);
        check("R11 eq after sync reset", {31'b0, eq_flag}, 32'h1);
        check("R11 lt after sync reset", {31'b0, lt_flag}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_idle();
        t_inc();
        t_alu();
        t_shift_big();
        t_cmp();
        t_mem();
        t_mul();
        t_div();
        t_call();
        t_stall();
        t_sync_reset();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule